// File: doc/BRIEF.md
# Oscillator Trim Calibrator

This block tunes a free-running oscillator by searching for the 7-bit trim code that brings it closest to a requested frequency. Software or a power sequencer gives a target in MHz and pulses a start input. The block drives the trim code to the oscillator. It asks an external frequency meter for a count and reads the count back. It times settling and meter timeouts from a one-microsecond tick.

A run always begins by measuring the code that is already applied. If that count is inside a plus or minus four percent window around the target, the run ends at once. Otherwise a bisection over the whole trim range narrows the code to two neighbours. Both neighbours are measured, and the one with the smaller error is applied and checked a last time. The final code, a pass or fail flag and a one-cycle done pulse report the outcome. The chosen code stays on the oscillator even when the last check fails.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, trim_o is 64 (parameter TRIM_INIT), and done_o, fail_o and meter_start_o are 0.
- R2: The target count is floor(target_mhz_i*1024/26). A count is accepted only when it is strictly greater than floor(target*960/1000) and strictly less than floor(target*1040/1000).
- R3: On start_i, the currently applied code is measured first, with no settle wait. If that count is accepted, the run ends after that single measurement, with result_o equal to the unchanged trim_o and fail_o at 0.
- R4: A rejected first check starts a bisection with low bound 0 and high bound 127. Each step applies mid=(low+high)/2. If the count is greater than the target, high becomes mid; otherwise low becomes mid. The loop ends when mid equals low, so a full search makes seven step measurements.
- R5: After the loop, the low bound and then the high bound are each applied and measured. The one with the smaller absolute error becomes the result, and an equal error selects the high bound.
- R6: After every trim code change, at least 50 us_tick_i pulses pass before the next meter_start_o. The trim code does not change while a measurement is pending.
- R7: The result is applied and measured once more. fail_o is set together with done_o when that count is not accepted, and trim_o still equals result_o.
- R8: If no meter_done_i arrives within 100 us_tick_i pulses of meter_start_o, the count is taken as 0.
- R9: meter_start_o and done_o are single-cycle pulses. result_o and fail_o hold until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calibration run when idle |
| target_mhz_i | input | 10 | Target frequency in MHz |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| meter_count_i | input | 16 | Count returned by the frequency meter |
| meter_done_i | input | 1 | Meter count valid pulse |
| meter_start_o | output | 1 | Pulse that starts one meter measurement |
| trim_o | output | 7 | Trim code applied to the oscillator |
| done_o | output | 1 | Run finished pulse |
| result_o | output | 7 | Final trim code of the last run |
| fail_o | output | 1 | Last run ended outside the acceptance window |

## Verification
On every cycle, the assertions check the pulse shape of meter_start_o and done_o, and that the code is stable during a pending measurement. They also check the tick count between a code change and the next meter start, and that the applied code equals the reported result and that a failure only appears with done. Other behaviours only show over a whole run, so only the bench scenarios can demonstrate them. These are the strict window edges, skipping the search on an accepted first check, the bisection outcome against an independent model, tie resolution toward the high bound, the timeout-as-zero path and the fail flag.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_SETTLE,
    ST_MEAS_START,
    ST_MEAS_WAIT,
    ST_DECIDE
  } cal_state_e;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_SEARCH,
    PH_LO,
    PH_HI,
    PH_FINAL
  } cal_phase_e;
endpackage

// File: rtl/cal_target.sv
module cal_target #(
  parameter int MHZ_W    = 10,
  parameter int CNT_W    = 16,
  parameter int SCALE    = 1024,
  parameter int REF_DIV  = 26,
  parameter int MISS_PM  = 40
) (
  input  logic [MHZ_W-1:0] mhz_i,
  output logic [CNT_W-1:0] tgt_o,
  output logic [CNT_W-1:0] win_lo_o,
  output logic [CNT_W-1:0] win_hi_o
);
  localparam int PW = MHZ_W + $clog2(SCALE) + 1;
  localparam int WW = CNT_W + 12;

  logic [PW-1:0] prod, quo;
  logic [WW-1:0] lo_p, hi_p, lo_q, hi_q;

  always_comb begin
    prod     = PW'(mhz_i) * PW'(SCALE);
    quo      = prod / PW'(REF_DIV);
    tgt_o    = CNT_W'(quo);
    lo_p     = WW'(tgt_o) * WW'(1000 - MISS_PM);
    hi_p     = WW'(tgt_o) * WW'(1000 + MISS_PM);
    lo_q     = lo_p / WW'(1000);
    hi_q     = hi_p / WW'(1000);
    win_lo_o = CNT_W'(lo_q);
    win_hi_o = CNT_W'(hi_q);
  end
endmodule

// File: rtl/cal_compare.sv
module cal_compare #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic [CNT_W-1:0] win_lo_i,
  input  logic [CNT_W-1:0] win_hi_i,
  output logic             in_win_o,
  output logic             above_o,
  output logic [CNT_W-1:0] err_o
);
  always_comb begin
    in_win_o = (cnt_i > win_lo_i) && (cnt_i < win_hi_i);
    above_o  = cnt_i > tgt_i;
    err_o    = above_o ? (cnt_i - tgt_i) : (tgt_i - cnt_i);
  end
endmodule

// File: rtl/cal_us_timer.sv
module cal_us_timer #(
  parameter int MAX_US = 100,
  localparam int TW    = $clog2(MAX_US + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_o <= '0;
    else if (clear_i)                              cnt_o <= '0;
    else if (tick_i && (cnt_o < TW'(MAX_US)))      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_cal_pkg::*;
#(
  parameter int TRIM_W     = 7,
  parameter int MHZ_W      = 10,
  parameter int CNT_W      = 16,
  parameter int TRIM_INIT  = 64,
  parameter int SETTLE_US  = 50,
  parameter int TIMEOUT_US = 100,
  parameter int MISS_PM    = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MHZ_W-1:0]  target_mhz_i,
  input  logic              us_tick_i,
  input  logic [CNT_W-1:0]  meter_count_i,
  input  logic              meter_done_i,
  output logic              meter_start_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              done_o,
  output logic [TRIM_W-1:0] result_o,
  output logic              fail_o
);
  localparam int TMR_MAX = (TIMEOUT_US > SETTLE_US) ? TIMEOUT_US : SETTLE_US;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  cal_state_e state_q;
  cal_phase_e phase_q;
  logic [TRIM_W-1:0] trim_q, min_q, max_q, result_q, mid;
  logic [TRIM_W:0]   sum;
  logic [CNT_W-1:0]  cnt_q, err_lo_q, tgt, win_lo, win_hi, err;
  logic              in_win, above, done_q, fail_q, tmr_clr;
  logic [TW-1:0]     tmr;

  cal_target #(
    .MHZ_W(MHZ_W), .CNT_W(CNT_W), .SCALE(1024), .REF_DIV(26), .MISS_PM(MISS_PM)
  ) i_target (
    .mhz_i(target_mhz_i), .tgt_o(tgt), .win_lo_o(win_lo), .win_hi_o(win_hi)
  );

  cal_compare #(.CNT_W(CNT_W)) i_compare (
    .cnt_i(cnt_q), .tgt_i(tgt), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .in_win_o(in_win), .above_o(above), .err_o(err)
  );

  assign tmr_clr = !((state_q == ST_SETTLE) || (state_q == ST_MEAS_WAIT));

  cal_us_timer #(.MAX_US(TMR_MAX)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(tmr_clr), .tick_i(us_tick_i), .cnt_o(tmr)
  );

  always_comb begin
    sum = {1'b0, min_q} + {1'b0, max_q};
    mid = sum[TRIM_W:1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_PRE;
      trim_q   <= TRIM_W'(TRIM_INIT);
      min_q    <= '0;
      max_q    <= TRIM_MAX;
      result_q <= TRIM_W'(TRIM_INIT);
      cnt_q    <= '0;
      err_lo_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          phase_q <= PH_PRE;
          state_q <= ST_MEAS_START;
        end
        ST_MEAS_START: state_q <= ST_MEAS_WAIT;
        ST_MEAS_WAIT: begin
          if (meter_done_i) begin
            cnt_q   <= meter_count_i;
            state_q <= ST_DECIDE;
          end else if (tmr >= TW'(TIMEOUT_US)) begin
            cnt_q   <= '0; // timeout reads as zero
            state_q <= ST_DECIDE;
          end
        end
        ST_SETTLE: if (tmr >= TW'(SETTLE_US)) state_q <= ST_MEAS_START;
        ST_STEP: begin
          if (mid == min_q) begin
            trim_q  <= min_q;
            phase_q <= PH_LO;
          end else begin
            trim_q  <= mid;
          end
          state_q <= ST_SETTLE;
        end
        ST_DECIDE: begin
          unique case (phase_q)
            PH_PRE: begin
              if (in_win) begin
                result_q <= trim_q;
                fail_q   <= 1'b0;
                done_q   <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                min_q   <= '0;
                max_q   <= TRIM_MAX;
                phase_q <= PH_SEARCH;
                state_q <= ST_STEP;
              end
            end
            PH_SEARCH: begin
              if (above) max_q <= trim_q;
              else       min_q <= trim_q;
              state_q <= ST_STEP;
            end
            PH_LO: begin
              err_lo_q <= err;
              trim_q   <= max_q;
              phase_q  <= PH_HI;
              state_q  <= ST_SETTLE;
            end
            PH_HI: begin
              trim_q  <= (err_lo_q < err) ? min_q : max_q; // tie keeps high bound
              phase_q <= PH_FINAL;
              state_q <= ST_SETTLE;
            end
            PH_FINAL: begin
              result_q <= trim_q;
              fail_q   <= !in_win;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign meter_start_o = (state_q == ST_MEAS_START);
  assign trim_o        = trim_q;
  assign done_o        = done_q;
  assign result_o      = result_q;
  assign fail_o        = fail_q;
endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
  parameter int TRIM_W    = 7,
  parameter int TRIM_INIT = 64,
  parameter int SETTLE_US = 50,
  localparam int CW       = $clog2(SETTLE_US + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              us_tick_i,
  input logic              meter_start_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic              done_o,
  input logic [TRIM_W-1:0] result_o,
  input logic              fail_o
);
  logic [TRIM_W-1:0] prev_q;
  logic              chg_q;
  logic [CW-1:0]     tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= TRIM_W'(TRIM_INIT);
      chg_q  <= 1'b0;
      tick_q <= '0;
    end else begin
      prev_q <= trim_o;
      if (trim_o != prev_q) begin
        chg_q  <= 1'b1;
        tick_q <= us_tick_i ? CW'(1) : CW'(0);
      end else begin
        if (us_tick_i && (tick_q < CW'(SETTLE_US))) tick_q <= tick_q + 1'b1;
        if (meter_start_o) chg_q <= 1'b0;
      end
    end
  end

  AST_MEAS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meter_start_o |=> !meter_start_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_SETTLE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meter_start_o && chg_q) |-> (tick_q >= CW'(SETTLE_US))); // R6
  AST_TRIM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meter_start_o |=> $stable(trim_o)); // R6
  AST_RESULT_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (trim_o == result_o)); // R7
  AST_FAIL_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o); // R7
endmodule

bind osc_trim_cal osc_trim_cal_chk #(
  .TRIM_W(TRIM_W), .TRIM_INIT(TRIM_INIT), .SETTLE_US(SETTLE_US)
) i_osc_trim_cal_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i),
  .meter_start_o(meter_start_o), .trim_o(trim_o), .done_o(done_o),
  .result_o(result_o), .fail_o(fail_o)
);

// File: tb/test_osc_trim_cal.sv
module test_osc_trim_cal;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  tgt_mhz = 10'd200;
  logic        tick = 1'b0;
  logic [15:0] m_count = '0;
  logic        m_done = 1'b0;
  logic        m_start;
  logic [6:0]  trim, result;
  logic        done, fail;

  int n_tests = 0, n_fail = 0;
  int base = 0, slope = 0, respond = 1;
  int sp_en = 0, sp_trim = 0, sp_val = 0;
  int n_starts = 0, ticks_since = 0, min_settle = 1000000, first_meas = 0;
  logic [6:0] last_trim = 7'd64;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_trim_cal i_osc_trim_cal (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_mhz_i(tgt_mhz),
    .us_tick_i(tick), .meter_count_i(m_count), .meter_done_i(m_done),
    .meter_start_o(m_start), .trim_o(trim), .done_o(done),
    .result_o(result), .fail_o(fail)
  );

  function automatic int model(int t, int b, int s);
    int c;
    c = b + s * t;
    if (c < 0) c = 0;
    if (c > 65535) c = 65535;
    return c;
  endfunction

  function automatic int tcount(int mhz);
    return (mhz * 1024) / 26;
  endfunction

  function automatic int ref_search(int tg, int b, int s);
    int lo, hi, mid, el, eh;
    lo = 0; hi = 127;
    forever begin
      mid = (lo + hi) / 2;
      if (mid == lo) break;
      if (model(mid, b, s) > tg) hi = mid; else lo = mid;
    end
    el = model(lo, b, s) - tg; if (el < 0) el = -el;
    eh = model(hi, b, s) - tg; if (eh < 0) eh = -eh;
    return (el < eh) ? lo : hi;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // microsecond tick: high every other cycle
  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // frequency meter model
  initial forever begin
    @(negedge clk);
    if (m_start && respond != 0) begin
      repeat (4) @(negedge clk);
      if (sp_en != 0 && int'(trim) == sp_trim) m_count = 16'(sp_val);
      else m_count = 16'(model(int'(trim), base, slope));
      m_done = 1'b1;
      @(negedge clk);
      m_done = 1'b0;
    end
  end

  // meter start / settle monitor
  initial forever begin
    @(negedge clk);
    if (m_start) begin
      n_starts++;
      if (first_meas == 0 && ticks_since < min_settle) min_settle = ticks_since;
      first_meas = 0;
    end
    if (trim != last_trim) begin
      last_trim   = trim;
      ticks_since = tick ? 1 : 0;
    end else if (tick) ticks_since++;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  task automatic run_cal(output int starts, output int res, output int fl);
    int waited = 0;
    @(negedge clk);
    n_starts = 0; first_meas = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    starts = n_starts; res = int'(result); fl = int'(fail);
    chk("R7 trim equals result at done", int'(trim), int'(result));
    @(negedge clk);
    chk("R9 done is one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 trim reset", int'(trim), 64);
    chk("R1 done reset", int'(done), 0);
    chk("R1 fail reset", int'(fail), 0);
    chk("R1 meter_start reset", int'(m_start), 0);
  endtask

  task automatic t_precheck_pass();
    int s, r, f;
    tgt_mhz = 10'd200; base = 1476; slope = 100; respond = 1; sp_en = 0;
    run_cal(s, r, f);
    chk("R3 single measurement", s, 1);
    chk("R3 result is current code", r, 64);
    chk("R3 pass", f, 0);
    chk("R9 result held", int'(result), 64);
  endtask

  task automatic t_window_edges();
    int s, r, f;
    tgt_mhz = 10'd200; base = 3000; slope = 100; respond = 1;
    chk("R2 target count", tcount(200), 7876);
    sp_en = 1; sp_trim = int'(trim); sp_val = 8190;
    run_cal(s, r, f);
    chk("R2 just below upper edge accepted", s, 1);
    sp_trim = int'(trim); sp_val = 8191;
    run_cal(s, r, f);
    chk("R2 upper edge rejected", s, 11);
    chk("R4 search result", r, ref_search(7876, 3000, 100));
    sp_trim = int'(trim); sp_val = 7560;
    run_cal(s, r, f);
    chk("R2 lower edge rejected", s, 11);
    sp_trim = int'(trim); sp_val = 7561;
    run_cal(s, r, f);
    chk("R2 just above lower edge accepted", s, 1);
    sp_en = 0;
  endtask

  task automatic t_search();
    int s, r, f, e;
    tgt_mhz = 10'd100; base = 1000; slope = 40; respond = 1; sp_en = 0;
    min_settle = 1000000;
    e = ref_search(tcount(100), 1000, 40);
    run_cal(s, r, f);
    chk("R4 step count plus checks", s, 11);
    chk("R5 closer bound chosen", r, e);
    chk("R7 final pass", f, 0);
    chk("R6 settle ticks at least 50", (min_settle >= 50) ? 1 : 0, 1);
  endtask

  task automatic t_timeout();
    int s, r, f;
    tgt_mhz = 10'd200; respond = 0;
    run_cal(s, r, f);
    chk("R8 timeout runs full search", s, 11);
    chk("R5 tie selects high bound", r, 127);
    chk("R7 fail raised", f, 1);
    chk("R7 code left applied", int'(trim), 127);
    chk("R9 fail held", int'(fail), 1);
    respond = 1;
  endtask

  task automatic t_recover();
    int s, r, f;
    tgt_mhz = 10'd200; base = 3000; slope = 100; respond = 1; sp_en = 0;
    run_cal(s, r, f);
    chk("R7 fail cleared on passing run", f, 0);
    chk("R5 result after recovery", r, ref_search(7876, 3000, 100));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_precheck_pass();
    t_window_edges();
    t_search();
    t_timeout();
    t_recover();
    finish_run();
  end
endmodule